// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash memory. It decides whether a program or erase operation that was already started inside the flash has finished. After a start pulse it issues status reads through a request/acknowledge read port. It compares the monitored toggle bit across each pair of consecutive reads and watches the exceeded-limit flag on bit 5. When the limit flag is set, it runs one more pair of reads before it declares failure. This covers the race in which the operation completes just as the flag rises.

The poll ends in one of three ways. A steady toggle bit means success. A toggle bit that still moves after the limit re-check means failure, and in that case the block writes a single reset command to the flash before it reports. An abort from the host ends the poll early so the host can do other work, and the next start then begins again from a fresh pair of reads. Each outcome is reported as a one-cycle pulse together with a two-bit code.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy, rd_req, wr_req and done are all low until start is seen.
- R2: A start pulse in idle begins a pair of reads. rd_req stays high until rd_ack, and each rd_ack cycle completes exactly one read. The second read of a pair follows the first with no gap.
- R3: If the monitored bit has the same value in both reads of a pair, done pulses with result 2'b01 (success) and no write is issued.
- R4: If the monitored bit differs within a pair and bit 5 of the second read is 0, another pair of reads follows.
- R5: If the monitored bit differs and bit 5 of the second read is 1, one re-check pair follows. If that pair shows a steady bit, the result is 2'b01.
- R6: If the re-check pair still differs, a single write of RESET_CMD (default 8'hF0) is issued. wr_req stays high until wr_ack, and done then pulses with result 2'b10 (fail). No read and write are ever requested together.
- R7: bit_sel = 0 monitors bit 6 and bit_sel = 1 monitors bit 2. The other toggle bit has no effect on the outcome.
- R8: An abort during the read phase ends the poll with done and result 2'b11, issues no write, and returns to idle. A later start begins with a full pair of reads. An abort in idle or during the reset write has no effect.
- R9: done lasts exactly one cycle, and busy is high from the cycle after start until the cycle done appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (accepted in idle) |
| abort | input | 1 | Abandon the poll during the read phase |
| bit_sel | input | 1 | 0: monitor bit 6, 1: monitor bit 2 |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge; rd_data valid this cycle |
| rd_data | input | DW | Status word from the flash |
| wr_req | output | 1 | Reset command write request |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DW | Command value (RESET_CMD) |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 01 success, 10 fail, 11 aborted |

## Verification
The hardest situation to reach is the race on the limit flag. The toggle bit must still differ in the pair where bit 5 first reads high, and must then settle exactly in the re-check pair, or else keep moving one pair longer. The stub flash model is driven by two numbers per vector: the read index at which the monitored bit freezes, and the read index from which bit 5 reads high. Placing these around the pair boundaries makes every branch occur at a read count known in advance. The other toggle bit keeps toggling throughout, so a wrong bit selection never converges and is caught.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_OK    = 2'b01,
    RES_FAIL  = 2'b10,
    RES_ABORT = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD_A = 2'b01,
    ST_RD_B = 2'b10,
    ST_WR   = 2'b11
  } st_e;
endpackage

// File: rtl/tpoll_bit_pick.sv
module tpoll_bit_pick #(
  parameter int DW      = 8,
  parameter int BIT_A   = 6,
  parameter int BIT_B   = 2,
  parameter int LIM_BIT = 5
) (
  input  logic [DW-1:0] data,
  input  logic          sel,
  output logic          tog,
  output logic          lim
);
  generate
    if (BIT_A == BIT_B) begin : g_single
      assign tog = data[BIT_A];
    end else begin : g_mux
      assign tog = sel ? data[BIT_B] : data[BIT_A];
    end
  endgenerate

  assign lim = data[LIM_BIT];
endmodule

// File: rtl/tpoll_sample.sv
module tpoll_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic tog_in,
  output logic same
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
    end else if (cap_en) begin
      first_q <= tog_in;
    end
  end

  assign same = (first_q == tog_in);
endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm
  import tpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       rd_ack,
  input  logic       wr_ack,
  input  logic       same,
  input  logic       lim,
  output logic       cap_en,
  output logic       rd_req,
  output logic       wr_req,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);
  st_e  state_q, state_d;
  logic chk_q, chk_d;
  logic done_q, done_d;
  res_e res_q, res_d;

  always_comb begin
    state_d = state_q;
    chk_d   = chk_q;
    done_d  = 1'b0;
    res_d   = res_q;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RD_A;
          chk_d   = 1'b0;
        end
      end
      ST_RD_A: begin
        if (abort) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = RES_ABORT;
        end else if (rd_ack) begin
          cap_en  = 1'b1;
          state_d = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (abort) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = RES_ABORT;
        end else if (rd_ack) begin
          if (same) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            res_d   = RES_OK;
          end else if (chk_q) begin
            state_d = ST_WR;
          end else begin
            chk_d   = lim;
            state_d = ST_RD_A;
          end
        end
      end
      ST_WR: begin
        if (wr_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = RES_FAIL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chk_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chk_q   <= chk_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_NONE;
    end else if (done_d) begin
      res_q <= res_d;
    end
  end

  assign rd_req = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign wr_req = (state_q == ST_WR);
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int           DW        = 8,
  parameter int           BIT_A     = 6,
  parameter int           BIT_B     = 2,
  parameter int           LIM_BIT   = 5,
  parameter logic [DW-1:0] RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          bit_sel,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  input  logic          wr_ack,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);
  logic tog, lim, same, cap_en;

  tpoll_bit_pick #(.DW(DW), .BIT_A(BIT_A), .BIT_B(BIT_B), .LIM_BIT(LIM_BIT)) u_pick (
    .data (rd_data),
    .sel  (bit_sel),
    .tog  (tog),
    .lim  (lim)
  );

  tpoll_sample u_sample (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .tog_in (tog),
    .same   (same)
  );

  tpoll_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .rd_ack (rd_ack),
    .wr_ack (wr_ack),
    .same   (same),
    .lim    (lim),
    .cap_en (cap_en),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  assign wr_data = RESET_CMD;
endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       abort,
  input logic       rd_req,
  input logic       rd_ack,
  input logic       wr_req,
  input logic       wr_ack,
  input logic       busy,
  input logic       done,
  input logic [1:0] result
);
  p_one_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !abort) |=> rd_req);

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);

  p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b10) |-> $past(wr_req && wr_ack));

  p_abort_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && abort) |=> (done && result == 2'b11));

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_ok_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b01) |-> $past(rd_req && rd_ack));
endmodule

bind toggle_poll_ctrl tpoll_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .abort  (abort),
  .rd_req (rd_req),
  .rd_ack (rd_ack),
  .wr_req (wr_req),
  .wr_ack (wr_ack),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/toggle_poll_ctrl_bench.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_bench;
  typedef struct packed {
    logic       sel;
    logic [7:0] tog_n;
    logic [7:0] lim_at;
    logic [1:0] exp_res;
    logic [7:0] exp_rd;
    logic       exp_wr;
    logic       ab_wr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 8'd0,  8'd99, 2'd1, 8'd2, 1'b0, 1'b0},
    '{1'b0, 8'd1,  8'd99, 2'd1, 8'd4, 1'b0, 1'b0},
    '{1'b0, 8'd5,  8'd99, 2'd1, 8'd8, 1'b0, 1'b0},
    '{1'b0, 8'd3,  8'd1,  2'd2, 8'd4, 1'b1, 1'b0},
    '{1'b0, 8'd2,  8'd1,  2'd1, 8'd4, 1'b0, 1'b0},
    '{1'b0, 8'd20, 8'd5,  2'd2, 8'd8, 1'b1, 1'b0},
    '{1'b1, 8'd3,  8'd99, 2'd1, 8'd6, 1'b0, 1'b0},
    '{1'b1, 8'd4,  8'd3,  2'd1, 8'd6, 1'b0, 1'b0},
    '{1'b0, 8'd3,  8'd1,  2'd2, 8'd4, 1'b1, 1'b1}
  };
  string tags [0:NV-1] = '{"R3", "R4", "R4", "R6", "R5", "R6", "R7", "R7", "R8"};

  logic clk, rst_n, start, abort, bit_sel;
  logic rd_req, rd_ack, wr_req, wr_ack, busy, done;
  logic [7:0] rd_data, wr_data;
  logic [1:0] result;

  logic dev_sel, cnt_clr;
  int   tog_n, lim_at, rd_cnt, wr_cnt;
  logic [7:0] wr_seen;
  int   checks, errors;

  toggle_poll_ctrl u_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .bit_sel(bit_sel),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
    .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] dev_word(int i, int tn, int la, logic s);
    logic [7:0] w;
    int m;
    w = 8'h80;
    m = (i < tn) ? i : tn;
    if (s) begin
      w[2] = m[0];
      w[6] = i[0];
    end else begin
      w[6] = m[0];
      w[2] = i[0];
    end
    w[5] = (i >= la);
    return w;
  endfunction

  assign rd_data = dev_word(rd_cnt, tog_n, lim_at, dev_sel);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      wr_ack  <= 1'b0;
      rd_cnt  <= 0;
      wr_cnt  <= 0;
      wr_seen <= 8'h00;
    end else begin
      rd_ack <= rd_req && !rd_ack;
      wr_ack <= wr_req && !wr_ack;
      if (cnt_clr) begin
        rd_cnt <= 0;
        wr_cnt <= 0;
      end else begin
        if (rd_ack) rd_cnt <= rd_cnt + 1;
        if (wr_ack) begin
          wr_cnt  <= wr_cnt + 1;
          wr_seen <= wr_data;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk) cnt_clr = 1'b1;
    @(negedge clk) cnt_clr = 1'b0;
  endtask

  task automatic wait_done(input bit ab_wr, output bit got);
    got = 1'b0;
    for (int c = 0; c < 400 && !got; c++) begin
      abort = ab_wr && wr_req;
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    abort = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    bit got;
    dev_sel = v.sel;
    tog_n   = int'(v.tog_n);
    lim_at  = int'(v.lim_at);
    bit_sel = v.sel;
    clear_counts();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    wait_done(v.ab_wr, got);
    check(got, {tag, " done seen"}, int'(got), 1);
    check(result == v.exp_res, {tag, " result"}, int'(result), int'(v.exp_res));
    check(rd_cnt == int'(v.exp_rd), {tag, " read count (R2)"}, rd_cnt, int'(v.exp_rd));
    check(wr_cnt == int'(v.exp_wr), {tag, " write count (R6)"}, wr_cnt, int'(v.exp_wr));
    if (v.exp_wr)
      check(wr_seen == 8'hF0, "R6 reset command value", int'(wr_seen), 240);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; bit_sel = 1'b0;
    dev_sel = 1'b0; cnt_clr = 1'b0; tog_n = 0; lim_at = 99;
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !wr_req && !done, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !wr_req && !done, "R1 after reset", int'(rd_req), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], tags[i]);

    // R8: abort in idle has no effect
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (2) @(negedge clk);
    check(!done && !busy, "R8 idle abort ignored", int'(done), 0);

    // R8: abort during the second read of a pair, then restart
    dev_sel = 1'b0; bit_sel = 1'b0; tog_n = 100; lim_at = 99;
    clear_counts();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!rd_ack) @(negedge clk);
    @(negedge clk) abort = 1'b1;
    @(negedge clk);
    check(done == 1'b1, "R8 abort done", int'(done), 1);
    check(result == 2'b11, "R8 abort code", int'(result), 3);
    check(wr_cnt == 0, "R8 no write on abort", wr_cnt, 0);
    abort = 1'b0;
    repeat (2) @(negedge clk);
    tog_n = 0;
    clear_counts();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(1'b0, got);
    check(got && result == 2'b01, "R8 restart result", int'(result), 1);
    check(rd_cnt == 2, "R8 restart full pair", rd_cnt, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule